// File: doc/BRIEF.md
# Six-Input Pair-Recoding Ones Counter

This block counts how many of six equally weighted bits are set and presents the result as a three-bit binary number. It is intended for the column-reduction tree of a multiplier, where one of its outputs feeds the same column and the other two feed the next two columns up. It has no clock and no state, so the result settles within one combinational path.

Before counting, the block recodes each adjacent pair of input bits into two signals: "both bits set" (AND) and "either bit set" (OR). Every later gate uses only these recoded signals. Two inputs that have the same number of ones inside each pair therefore always give the same result, and the 64 input patterns collapse to 27 distinct cases.

The elaboration parameter `APPROX` selects one of three variants. Mode 0 gives the exact count. Mode 1 replaces the weight-1 output with a cheaper approximation. Mode 2 approximates both the weight-1 and the weight-2 outputs. In every mode the weight-4 output stays exact. The approximate modes are meant for error-tolerant data such as image pixels.

Top module: `psc63_counter`

## Requirements
- R1: With APPROX=0, the value {cnt4_o, cnt2_o, cnt1_o} read as an unsigned number (cnt4_o is the MSB) equals the number of ones in x_i, for all 64 inputs.
- R2: In every mode, swapping the two bits of any input pair (x_i[1:0], x_i[3:2] or x_i[5:4]) leaves all three outputs unchanged.
- R3: With APPROX=1, cnt1_o equals the XOR of the three pair-OR signals (x_i[1]|x_i[0]), (x_i[3]|x_i[2]) and (x_i[5]|x_i[4]).
- R4: With APPROX=1, cnt2_o and cnt4_o equal bits 1 and 2 of the exact count of ones.
- R5: With APPROX=2, cnt1_o follows the same rule as in R3.
- R6: With APPROX=2, cnt2_o equals (OR of the three pair-AND signals) XOR (majority of the three pair-OR signals).
- R7: In every mode, cnt4_o is 1 exactly when four or more input bits are set.
- R8: An all-zero input gives 000 in every mode. An all-ones input gives 110 in mode 0, 111 in mode 1 and 101 in mode 2.
- R9: With APPROX=1, the three-bit result differs from the exact count for exactly 28 of the 64 inputs, a pass rate of 36/64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 6 | Six equal-weight bits; pairs are [1:0], [3:2], [5:4] |
| cnt1_o | output | 1 | Weight-1 bit of the count |
| cnt2_o | output | 1 | Weight-2 bit of the count |
| cnt4_o | output | 1 | Weight-4 bit of the count |

## Verification
The bound checker evaluates combinational assertions. These assume that x_i carries known 0/1 values and that the outputs are compared only after they have settled on a changed input. The bench holds each input vector steady for a full clock period and drives only defined values. It applies every one of the 64 codes to one instance per mode, so each assertion sees its whole input space.

// File: rtl/psc63_pkg.sv
package psc63_pkg;

    localparam int PAIRS  = 3;
    localparam int IN_W   = 2 * PAIRS;
    localparam int CNT_W  = 3;

    typedef enum int {
        MODE_EXACT = 0,
        MODE_LOW   = 1,
        MODE_MID   = 2
    } mode_e;

    typedef struct packed {
        logic both;
        logic any;
    } pair_t;

    typedef pair_t [PAIRS-1:0] pairs_t;

    typedef struct packed {
        logic w4;
        logic w2;
        logic w1;
    } cnt_t;

    function automatic logic maj3(input logic p, input logic q, input logic r);
        return (p & q) | (p & r) | (q & r);
    endfunction

endpackage

// File: rtl/psc63_shuffle.sv
module psc63_shuffle
    import psc63_pkg::*;
(
    input  logic [IN_W-1:0] x_i,
    output pairs_t          pr_o
);
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign pr_o[g].both = x_i[2*g+1] & x_i[2*g];
        assign pr_o[g].any  = x_i[2*g+1] | x_i[2*g];
    end
endmodule

// File: rtl/psc63_low.sv
module psc63_low
    import psc63_pkg::*;
#(
    parameter int APPROX = 0
) (
    input  pairs_t pr_i,
    output logic   w1_o
);
    localparam logic KEEP_FULL = (APPROX == MODE_EXACT);

    logic any_par;
    logic both_par;

    always_comb begin
        any_par  = 1'b0;
        both_par = 1'b0;
        for (int k = 0; k < PAIRS; k++) begin
            any_par  = any_par ^ pr_i[k].any;
            both_par = both_par ^ pr_i[k].both;
        end
        w1_o = any_par ^ (both_par & KEEP_FULL);
    end
endmodule

// File: rtl/psc63_mid.sv
module psc63_mid
    import psc63_pkg::*;
#(
    parameter int APPROX = 0
) (
    input  pairs_t pr_i,
    output logic   w2_o
);
    if (APPROX == MODE_MID) begin : g_apx
        assign w2_o = (pr_i[0].both | pr_i[1].both | pr_i[2].both)
                    ^ maj3(pr_i[0].any, pr_i[1].any, pr_i[2].any);
    end else begin : g_full
        logic [PAIRS-1:0] odd;
        for (genvar g = 0; g < PAIRS; g++) begin : g_odd
            assign odd[g] = pr_i[g].any ^ pr_i[g].both;
        end
        assign w2_o = (pr_i[0].both ^ pr_i[1].both ^ pr_i[2].both)
                    ^ maj3(odd[0], odd[1], odd[2]);
    end
endmodule

// File: rtl/psc63_high.sv
module psc63_high
    import psc63_pkg::*;
(
    input  pairs_t pr_i,
    output logic   w4_o
);
    logic [PAIRS-1:0] odd;
    logic full_hi;
    logic full_lo;
    logic odd_carry;

    for (genvar g = 0; g < PAIRS; g++) begin : g_odd
        assign odd[g] = pr_i[g].any ^ pr_i[g].both;
    end

    assign full_hi   = maj3(pr_i[0].both, pr_i[1].both, pr_i[2].both);
    assign full_lo   = pr_i[0].both ^ pr_i[1].both ^ pr_i[2].both;
    assign odd_carry = maj3(odd[0], odd[1], odd[2]);
    assign w4_o      = full_hi | (full_lo & odd_carry);
endmodule

// File: rtl/psc63_counter.sv
module psc63_counter
    import psc63_pkg::*;
#(
    parameter int APPROX = 0
) (
    input  logic [5:0] x_i,
    output logic       cnt1_o,
    output logic       cnt2_o,
    output logic       cnt4_o
);
    pairs_t pr;
    cnt_t   res;

    psc63_shuffle u_shuf (.x_i(x_i), .pr_o(pr));

    psc63_low  #(.APPROX(APPROX)) u_low  (.pr_i(pr), .w1_o(res.w1));
    psc63_mid  #(.APPROX(APPROX)) u_mid  (.pr_i(pr), .w2_o(res.w2));
    psc63_high                    u_high (.pr_i(pr), .w4_o(res.w4));

    assign cnt1_o = res.w1;
    assign cnt2_o = res.w2;
    assign cnt4_o = res.w4;
endmodule

// File: rtl/psc63_counter_chk.sv
module psc63_counter_chk #(
    parameter int APPROX = 0
) (
    input logic [5:0] x_i,
    input logic       cnt1_o,
    input logic       cnt2_o,
    input logic       cnt4_o
);
    logic [2:0] ones;
    logic [2:0] orp;
    logic [2:0] andp;

    always_comb begin
        ones = 3'($countones(x_i));
        orp  = {x_i[5] | x_i[4], x_i[3] | x_i[2], x_i[1] | x_i[0]};
        andp = {x_i[5] & x_i[4], x_i[3] & x_i[2], x_i[1] & x_i[0]};

        if (APPROX == 0) begin
            assert_exact_count_R1: assert ({cnt4_o, cnt2_o, cnt1_o} == ones);
        end
        if (APPROX != 0) begin
            // R3 and R5 share one rule
            assert_low_approx_R3: assert (cnt1_o == ^orp);
        end
        if (APPROX == 1) begin
            assert_mid_exact_R4: assert (cnt2_o == ones[1]);
        end
        if (APPROX == 2) begin
            assert_mid_approx_R6: assert (cnt2_o == ((|andp) ^
                ((orp[0] & orp[1]) | (orp[0] & orp[2]) | (orp[1] & orp[2]))));
        end
        assert_high_exact_R7: assert (cnt4_o == (ones >= 3'd4));
        if (x_i == 6'd0) begin
            assert_zero_in_R8: assert ({cnt4_o, cnt2_o, cnt1_o} == 3'b000);
        end
    end
endmodule

bind psc63_counter psc63_counter_chk #(.APPROX(APPROX)) u_chk (
    .x_i(x_i), .cnt1_o(cnt1_o), .cnt2_o(cnt2_o), .cnt4_o(cnt4_o)
);

// File: tb/psc63_counter_test.sv
module psc63_counter_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [5:0] x;
    logic [2:0] r0, r1, r2;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    psc63_counter #(.APPROX(0)) uut    (.x_i(x), .cnt1_o(r0[0]), .cnt2_o(r0[1]), .cnt4_o(r0[2]));
    psc63_counter #(.APPROX(1)) uut_d1 (.x_i(x), .cnt1_o(r1[0]), .cnt2_o(r1[1]), .cnt4_o(r1[2]));
    psc63_counter #(.APPROX(2)) uut_d2 (.x_i(x), .cnt1_o(r2[0]), .cnt2_o(r2[1]), .cnt4_o(r2[2]));

    // {x, exact, mode1, mode2}
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {6'b000000, 3'd0, 3'd0, 3'd0},
        {6'b111111, 3'd6, 3'd7, 3'd5},
        {6'b000001, 3'd1, 3'd1, 3'd1},
        {6'b100000, 3'd1, 3'd1, 3'd1},
        {6'b000011, 3'd2, 3'd3, 3'd3},
        {6'b110000, 3'd2, 3'd3, 3'd3},
        {6'b010101, 3'd3, 3'd3, 3'd3},
        {6'b001111, 3'd4, 3'd4, 3'd4},
        {6'b111110, 3'd5, 3'd5, 3'd5},
        {6'b011011, 3'd4, 3'd5, 3'd5}
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s x=%b actual=%0d expected=%0d", req, x, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] v);
        @(posedge clk);
        x = v;
        @(negedge clk);
    endtask

    function automatic logic [2:0] model(input logic [5:0] v, input int mode);
        logic [2:0] cnt;
        logic [2:0] o, a;
        logic s, c1;
        cnt = 3'($countones(v));
        o = {v[5] | v[4], v[3] | v[2], v[1] | v[0]};
        a = {v[5] & v[4], v[3] & v[2], v[1] & v[0]};
        s = (mode == 0) ? cnt[0] : ^o;
        c1 = (mode == 2) ? ((|a) ^ ((o[0] & o[1]) | (o[0] & o[2]) | (o[1] & o[2]))) : cnt[1];
        return {cnt[2], c1, s};
    endfunction

    function automatic logic [5:0] swap_pair(input logic [5:0] v, input int p);
        logic [5:0] w;
        w = v;
        w[2*p]   = v[2*p+1];
        w[2*p+1] = v[2*p];
        return w;
    endfunction

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL watchdog expired actual=running expected=done");
                    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [2:0] ref0, ref1, ref2;
        int err1;
        x = 6'd0;

        // Directed table: R8 corners plus distinct patterns (R1, R3..R6)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][14:9]);
            check("R1/R8 exact table", r0, VEC[i][8:6]);
            check("R3/R4/R8 mode1 table", r1, VEC[i][5:3]);
            check("R5/R6/R8 mode2 table", r2, VEC[i][2:0]);
        end

        // Exhaustive sweep of all modes
        err1 = 0;
        for (int v = 0; v < 64; v++) begin
            apply(6'(v));
            ref0 = model(6'(v), 0);
            ref1 = model(6'(v), 1);
            ref2 = model(6'(v), 2);
            check("R1 exact popcount", r0, ref0);
            check("R3 mode1 low bit", {2'b00, r1[0]}, {2'b00, ref1[0]});
            check("R4 mode1 upper bits", {1'b0, r1[2:1]}, {1'b0, ref0[2:1]});
            check("R5 mode2 low bit", {2'b00, r2[0]}, {2'b00, ref2[0]});
            check("R6 mode2 mid bit", {2'b00, r2[1]}, {2'b00, ref2[1]});
            check("R7 high bit mode1", {2'b00, r1[2]}, {2'b00, ref0[2]});
            check("R7 high bit mode2", {2'b00, r2[2]}, {2'b00, ref0[2]});
            if (r1 != ref0) err1++;
        end
        check("R9 mode1 error count", 3'(err1 / 8), 3'(28 / 8));
        check("R9 mode1 error count rem", 3'(err1 % 8), 3'(28 % 8));
        $display("mode1 errors=%0d pass rate=%0d/64", err1, 64 - err1);

        // Pair-swap invariance
        for (int v = 0; v < 64; v++) begin
            for (int p = 0; p < 3; p++) begin
                apply(6'(v));
                ref0 = r0; ref1 = r1; ref2 = r2;
                apply(swap_pair(6'(v), p));
                check("R2 swap mode0", r0, ref0);
                check("R2 swap mode1", r1, ref1);
                check("R2 swap mode2", r2, ref2);
            end
        end

        // Return to zero input after activity
        apply(6'b111111);
        apply(6'b000000);
        check("R8 zero mode0", r0, 3'd0);
        check("R8 zero mode1", r1, 3'd0);
        check("R8 zero mode2", r2, 3'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule